// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block sits between a core's data path and a wide active-low parallel bus and limits how many wires switch from one transfer to the next. The 64-bit word is handled as four 16-bit lanes. For each lane the transmit side counts how many wires would change level relative to what the bus currently carries. If that count is above half the lane width, the lane goes out with its bits flipped and a per-lane inversion flag is asserted, so that at most half of a lane's data wires ever switch per transfer.

The receive side takes the wire image and the per-lane flags and recovers the true data by undoing the active-low convention and any inversion. Each side has its own valid strobe. The transmit side registers its wire image and only advances it on valid cycles, so the bus holds its level while idle. The receive side is either purely combinational or has one output register, chosen by a parameter.

Top module: `dbi_codec`

## Requirements
- R1: Lane k (k = 0..3) covers data and wire bits [16k+15:16k] and is governed by flag bit k only; a decision in one lane never affects another.
- R2: A lane is sent inverted when 9 or more of its 16 wires would change level if it were sent uninverted.
- R3: A lane with 8 or fewer would-be changes, including exactly 8, is sent uninverted.
- R4: Wires and flags are active-low: an uninverted lane drives the complement of its data and its flag wire high; an inverted lane drives its data unchanged and its flag wire low (0).
- R5: While reset is held and after its release, the transmit wires and flags are all ones and both output valids are 0.
- R6: The change count is taken against the wire image last driven (after any inversion), not against the previous raw data word.
- R7: Wires and flags update one clock after a cycle with tx_valid_i high, tx_valid_o is tx_valid_i delayed by one clock, and the wires and flags hold their value when tx_valid_i is low.
- R8: The decoder returns, per lane, the complement of the lane wires when its flag wire is high and the lane wires unchanged when its flag wire is low; decoding an encoder output returns the original word.
- R9: With the default output register, rx_data_o and rx_valid_o appear one clock after the rx inputs are presented; rx_valid_o is rx_valid_i delayed by one clock.
- R10: Between two successive driven words no lane changes more than 8 of its 16 data wires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid_i | input | 1 | Word on tx_data_i is to be sent |
| tx_data_i | input | 64 | True (active-high) data to send |
| tx_valid_o | output | 1 | A new word was placed on the wires |
| tx_bus_n_o | output | 64 | Active-low data wires |
| tx_flag_n_o | output | 4 | Active-low per-lane inversion flags |
| rx_valid_i | input | 1 | Wire image on rx inputs is valid |
| rx_bus_n_i | input | 64 | Received active-low data wires |
| rx_flag_n_i | input | 4 | Received active-low inversion flags |
| rx_valid_o | output | 1 | Decoded word valid |
| rx_data_o | output | 64 | Decoded true data |

## Verification
On every cycle the assertions check that no lane switches more than half its data wires between driven words, that each flag agrees with whether its lane wires equal or complement the data that was presented, that the wire image holds through idle cycles, and that the decoder's lanes are either the wire image or its complement as the flags demand. Only the bench's scenarios can show the exact-threshold behaviour (8 versus 9 changes), that the comparison follows the previously driven wire image rather than the previous raw word, that lanes decide independently, and that decoding the encoder's output gives back the original word across long random and sparse-change sequences.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
   // Default geometry of the codec.
   localparam int unsigned DEF_DATA_W = 64;
   localparam int unsigned DEF_LANE_W = 16;

   // Number of lanes for a given geometry.
   function automatic int unsigned lane_count(input int unsigned data_w, input int unsigned lane_w);
      return data_w / lane_w;
   endfunction

   // Width of a counter able to hold 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
   import dbi_pkg::*;
#(
   parameter int unsigned LANE_W = DEF_LANE_W
) (
   input  logic [LANE_W-1:0] data_i,
   input  logic [LANE_W-1:0] prev_wire_i,
   output logic [LANE_W-1:0] wire_o,
   output logic              inv_o
);
   localparam int unsigned CNT_W = cnt_width(LANE_W);
   localparam int unsigned HALF  = LANE_W / 2;

   logic [LANE_W-1:0] plain_wire;
   logic [LANE_W-1:0] diff;
   logic [CNT_W-1:0]  n_change;

   // Active-low: an uninverted lane drives the complement of the data.
   assign plain_wire = ~data_i;
   assign diff       = plain_wire ^ prev_wire_i;

   always_comb begin
      n_change = '0;
      for (int i = 0; i < int'(LANE_W); i++) begin
         n_change = n_change + CNT_W'(diff[i]);
      end
   end

   // Strictly more than half must change before the lane is flipped.
   assign inv_o  = (n_change > CNT_W'(HALF));
   assign wire_o = inv_o ? data_i : plain_wire;
endmodule

// File: rtl/dbi_tx.sv
module dbi_tx
   import dbi_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned LANE_W = DEF_LANE_W
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 valid_i,
   input  logic [DATA_W-1:0]                    data_i,
   output logic                                 valid_o,
   output logic [DATA_W-1:0]                    bus_n_o,
   output logic [lane_count(DATA_W,LANE_W)-1:0] flag_n_o
);
   localparam int unsigned LANES = lane_count(DATA_W, LANE_W);
   localparam int unsigned HALF  = LANE_W / 2;

   logic [DATA_W-1:0] bus_q;
   logic [LANES-1:0]  flag_q;
   logic              valid_q;
   logic [DATA_W-1:0] nxt_wire;
   logic [LANES-1:0]  nxt_inv;

   for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
      dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
         .data_i      (data_i[k*LANE_W +: LANE_W]),
         .prev_wire_i (bus_q[k*LANE_W +: LANE_W]),
         .wire_o      (nxt_wire[k*LANE_W +: LANE_W]),
         .inv_o       (nxt_inv[k])
      );

      // R10: at most half the data wires of a lane switch per driven word
      assert_toggle_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> ($countones(bus_q[k*LANE_W +: LANE_W] ^ $past(bus_q[k*LANE_W +: LANE_W])) <= HALF));

      // R4: a low flag means the wires carry the data itself, a high flag its complement
      assert_flag_meaning_R4: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> (bus_q[k*LANE_W +: LANE_W] ==
                      (flag_q[k] ? ~$past(data_i[k*LANE_W +: LANE_W])
                                 :  $past(data_i[k*LANE_W +: LANE_W]))));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_q   <= '1;
         flag_q  <= '1;
         valid_q <= 1'b0;
      end else begin
         valid_q <= valid_i;
         if (valid_i) begin
            bus_q  <= nxt_wire;
            flag_q <= ~nxt_inv;
         end
      end
   end

   // R7: the wire image and flags hold across idle cycles
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(bus_q) && $stable(flag_q)));

   // R7: output valid follows input valid by one clock
   assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_q);

   assign valid_o  = valid_q;
   assign bus_n_o  = bus_q;
   assign flag_n_o = flag_q;
endmodule

// File: rtl/dbi_rx.sv
module dbi_rx
   import dbi_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter bit          RX_REG = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 valid_i,
   input  logic [DATA_W-1:0]                    bus_n_i,
   input  logic [lane_count(DATA_W,LANE_W)-1:0] flag_n_i,
   output logic                                 valid_o,
   output logic [DATA_W-1:0]                    data_o
);
   localparam int unsigned LANES = lane_count(DATA_W, LANE_W);

   logic [DATA_W-1:0] dec;

   for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
      // Undo the active-low convention, then undo inversion when the flag is low.
      assign dec[k*LANE_W +: LANE_W] = ~bus_n_i[k*LANE_W +: LANE_W] ^ {LANE_W{~flag_n_i[k]}};
   end

   if (RX_REG) begin : g_reg
      logic [DATA_W-1:0] data_q;
      logic              valid_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= valid_i;
            if (valid_i) data_q <= dec;
         end
      end

      assign data_o  = data_q;
      assign valid_o = valid_q;

      // R9: registered valid tracks the input valid one clock later
      assert_rx_valid_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> valid_q);
      assert_rx_valid_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> !valid_q);

      for (genvar k = 0; k < int'(LANES); k++) begin : g_chk
         // R8: each decoded lane equals the received wires or their complement, as the flag says
         assert_rx_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> ((data_q[k*LANE_W +: LANE_W] ^ $past(bus_n_i[k*LANE_W +: LANE_W]))
                          == {LANE_W{$past(flag_n_i[k])}}));
      end
   end else begin : g_comb
      assign data_o  = dec;
      assign valid_o = valid_i;
   end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
   import dbi_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter bit          RX_REG = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 tx_valid_i,
   input  logic [DATA_W-1:0]                    tx_data_i,
   output logic                                 tx_valid_o,
   output logic [DATA_W-1:0]                    tx_bus_n_o,
   output logic [lane_count(DATA_W,LANE_W)-1:0] tx_flag_n_o,
   input  logic                                 rx_valid_i,
   input  logic [DATA_W-1:0]                    rx_bus_n_i,
   input  logic [lane_count(DATA_W,LANE_W)-1:0] rx_flag_n_i,
   output logic                                 rx_valid_o,
   output logic [DATA_W-1:0]                    rx_data_o
);
   // Elaboration-time parameter checks.
   if (LANE_W < 2) begin : g_bad_lane
      $error("dbi_codec: LANE_W must be at least 2");
   end
   if ((DATA_W % LANE_W) != 0) begin : g_bad_split
      $error("dbi_codec: DATA_W must be a multiple of LANE_W");
   end

   dbi_tx #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (tx_valid_i),
      .data_i   (tx_data_i),
      .valid_o  (tx_valid_o),
      .bus_n_o  (tx_bus_n_o),
      .flag_n_o (tx_flag_n_o)
   );

   dbi_rx #(.DATA_W(DATA_W), .LANE_W(LANE_W), .RX_REG(RX_REG)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (rx_valid_i),
      .bus_n_i  (rx_bus_n_i),
      .flag_n_i (rx_flag_n_i),
      .valid_o  (rx_valid_o),
      .data_o   (rx_data_o)
   );

   // R5: bus idles high with flags deasserted right after reset
   assert_reset_idle_R5: assert property (@(posedge clk)
      !rst_n |=> (tx_bus_n_o == '1 && tx_flag_n_o == '1 && !tx_valid_o));
endmodule

// File: tb/sim_dbi_codec.sv
`timescale 1ns/1ps
module sim_dbi_codec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_valid_i = 1'b0;
   logic [63:0] tx_data_i = '0;
   logic        tx_valid_o;
   logic [63:0] tx_bus_n_o;
   logic [3:0]  tx_flag_n_o;
   logic        rx_valid_i = 1'b0;
   logic [63:0] rx_bus_n_i = '1;
   logic [3:0]  rx_flag_n_i = '1;
   logic        rx_valid_o;
   logic [63:0] rx_data_o;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [63:0] m_wire = '1;
   logic [3:0]  m_flag = '1;
   logic [67:0] last_exp;

   always #2.5 clk = ~clk;

   dbi_codec u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
      .tx_valid_o(tx_valid_o), .tx_bus_n_o(tx_bus_n_o), .tx_flag_n_o(tx_flag_n_o),
      .rx_valid_i(rx_valid_i), .rx_bus_n_i(rx_bus_n_i), .rx_flag_n_i(rx_flag_n_i),
      .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
   );

   // Reference encoder from the requirements: {flags_n, wires_n}.
   function automatic logic [67:0] model_enc(input logic [63:0] d, input logic [63:0] prev);
      logic [63:0] w;
      logic [3:0]  f;
      for (int k = 0; k < 4; k++) begin
         logic [15:0] plain;
         plain = ~d[k*16 +: 16];
         if ($countones(plain ^ prev[k*16 +: 16]) > 8) begin
            w[k*16 +: 16] = d[k*16 +: 16];
            f[k] = 1'b0;
         end else begin
            w[k*16 +: 16] = plain;
            f[k] = 1'b1;
         end
      end
      return {f, w};
   endfunction

   function automatic logic [63:0] model_dec(input logic [63:0] w, input logic [3:0] f);
      logic [63:0] d;
      for (int k = 0; k < 4; k++) d[k*16 +: 16] = f[k] ? ~w[k*16 +: 16] : w[k*16 +: 16];
      return d;
   endfunction

   task automatic check(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Send one word, check the wire image, then loop it back through the decoder.
   task automatic send(input logic [63:0] d, input string req);
      logic [67:0] exp;
      exp = model_enc(d, m_wire);
      @(negedge clk);
      tx_valid_i = 1'b1;
      tx_data_i  = d;
      @(negedge clk);
      tx_valid_i = 1'b0;
      check(tx_valid_o == 1'b1, "R7 tx_valid_o", 68'(tx_valid_o), 68'd1);
      check({tx_flag_n_o, tx_bus_n_o} == exp, req, {tx_flag_n_o, tx_bus_n_o}, exp);
      for (int k = 0; k < 4; k++) begin
         int n;
         n = $countones(tx_bus_n_o[k*16 +: 16] ^ m_wire[k*16 +: 16]);
         check(n <= 8, "R10 lane toggle count", 68'(n), 68'd8);
      end
      rx_valid_i  = 1'b1;
      rx_bus_n_i  = tx_bus_n_o;
      rx_flag_n_i = tx_flag_n_o;
      m_wire   = exp[63:0];
      m_flag   = exp[67:64];
      last_exp = exp;
      @(negedge clk);
      rx_valid_i = 1'b0;
      check(rx_valid_o && rx_data_o == d, "R8 round trip", {3'b0, rx_valid_o, rx_data_o}, {4'b0001, d});
   endtask

   // Watchdog: an expired run counts as one failed check.
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] w;
      logic [3:0]  f;
      logic [63:0] hold_bus;
      logic [3:0]  hold_flag;
      logic [63:0] d;
      void'($urandom(32'd24681));

      repeat (4) @(negedge clk);
      // R5: reset state while reset is held
      check(tx_bus_n_o == '1 && tx_flag_n_o == 4'hF && !tx_valid_o && !rx_valid_o,
            "R5 reset state", {tx_flag_n_o, tx_bus_n_o}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_bus_n_o == '1 && tx_flag_n_o == 4'hF && !tx_valid_o,
            "R5 after release", {tx_flag_n_o, tx_bus_n_o}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});

      // R4: zeros drive high wires, no inversion
      send(64'h0, "R4 zeros uninverted");
      check(last_exp[67:64] == 4'hF && tx_bus_n_o == '1, "R4 zeros wires high",
            {tx_flag_n_o, tx_bus_n_o}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
      // R2: all ones would switch every wire, all lanes invert
      send(64'hFFFF_FFFF_FFFF_FFFF, "R2 full toggle");
      check(tx_flag_n_o == 4'h0, "R2 all flags low", 68'(tx_flag_n_o), 68'h0);
      // R6: previous raw word was all ones but the wires stayed high, so zeros cause no change
      send(64'h0, "R6 against wire state");
      check(tx_flag_n_o == 4'hF && tx_bus_n_o == '1, "R6 no inversion",
            {tx_flag_n_o, tx_bus_n_o}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
      // R3 / R2: lanes 0 and 2 need 9 changes, lanes 1 and 3 exactly 8
      send(64'h00FF_01FF_00FF_01FF, "R3 threshold word");
      check(tx_flag_n_o == 4'b1010, "R3 exactly 8 stays, 9 inverts", 68'(tx_flag_n_o), 68'(4'b1010));
      send(64'h0, "R1 settle");
      // R1: only lane 0 crosses the threshold
      send(64'h0000_0000_0000_FFFF, "R1 single lane");
      check(tx_flag_n_o == 4'b1110, "R1 lane 0 only", 68'(tx_flag_n_o), 68'(4'b1110));

      // R7: idle cycles with changing data leave wires and flags alone
      hold_bus  = tx_bus_n_o;
      hold_flag = tx_flag_n_o;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         tx_data_i = {$urandom, $urandom};
      end
      @(negedge clk);
      check(tx_bus_n_o == hold_bus && tx_flag_n_o == hold_flag && !tx_valid_o, "R7 idle hold",
            {tx_flag_n_o, tx_bus_n_o}, {hold_flag, hold_bus});

      // Random words: dense random and sparse changes against the last word.
      d = 64'h0;
      for (int i = 0; i < 400; i++) begin
         if (i % 3 == 0) d = {$urandom, $urandom};
         else            d = d ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         send(d, "R2 R3 random encode");
      end

      // R8 / R9: decoder driven directly with arbitrary flags
      for (int i = 0; i < 60; i++) begin
         w = {$urandom, $urandom};
         f = 4'($urandom);
         @(negedge clk);
         rx_valid_i  = 1'b1;
         rx_bus_n_i  = w;
         rx_flag_n_i = f;
         #1;
         check(rx_valid_o == 1'b0, "R9 no early valid", 68'(rx_valid_o), 68'd0);
         @(negedge clk);
         rx_valid_i = 1'b0;
         check(rx_valid_o == 1'b1, "R9 valid after one clock", 68'(rx_valid_o), 68'd1);
         check(rx_data_o == model_dec(w, f), "R8 direct decode", 68'(rx_data_o), 68'(model_dec(w, f)));
         @(negedge clk);
         check(rx_valid_o == 1'b0, "R9 valid drops", 68'(rx_valid_o), 68'd0);
      end

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule